// File: doc/BRIEF.md
# Paged Wiper and Data Register Bank

This block is the register back end of a four-channel digital potentiometer. Each channel owns one volatile wiper register, whose value positions the wiper, and four data registers that stand in for nonvolatile storage. The data registers form a grid of rows and columns: a column belongs to one channel, and a row holds one data register for each channel. A small status register picks a row and decides whether serial accesses reach the wiper registers or that row of data registers. Whenever a data-register row is selected, written or read, its values also move into the wiper registers.

A byte-level serial slave front end drives the block with one-cycle event pulses: transfer start (with a read flag), a received byte, an acknowledged read byte, and stop. The first byte of a write transfer is an address byte. Later bytes are data and walk the column pointer around the row. Bytes meant for data registers are buffered and committed when the transfer stops, but only if write protect is high. The commit then holds a busy flag for a programmable number of clock cycles, which models the storage write time, and updates the data registers at the end of that time. A separate up/down front end can request a store of one channel's wiper into row 0. After reset the block spends one cycle recalling row 0 into the wipers.

Top module: `wiper_bank`

## Requirements
- R1: While reset is held and in the first cycle after it, busy_o is 1 and every wiper reads 0x00. From the second cycle on, wiper i equals data register row 0, column i, taken from DR_INIT. DR_INIT bit field [(row*N_DCP+col)*DW +: DW] gives each data register's reset value.
- R2: An address byte of 0 to 3 selects that column. 7 selects the status register. Any other value selects nothing: later data bytes change no register, and reads return 0x00.
- R3: A data byte to the status register keeps bits 2:0, where bit 0 = 1 means data-register access and bits 2:1 = row. Reserved bits read back as 0. When bit 0 is 1, every wiper loads the chosen row in the next cycle. No busy follows.
- R4: When status bit 0 is 0, each data byte writes the wiper of the current column at once. The column then steps 3→0 modulo 4, and a fifth byte overwrites the first. No busy follows.
- R5: When status bit 0 is 1, a data byte is buffered for the current column and written into that column's wiper. Each other wiper takes its byte buffered in this transfer if there is one, and otherwise its data register in the row. The column then wraps as in R4.
- R6: A stop with buffered bytes and wp_i = 1 raises busy_o in the next cycle for exactly BUSY_CYCLES cycles. The row is updated when busy falls. With wp_i = 0 the buffer is dropped, busy_o stays 0 and the data registers keep their values.
- R7: rd_data_o shows the target register. For the status register it is {00000, status}. For a column with status bit 0 = 0 it is that wiper, and with bit 0 = 1 it is the data register at (row, column). Each acknowledged read byte steps the column. With bit 0 = 1 it also copies the data register that was read into that column's wiper.
- R8: While busy_o is 1, transfer start, data bytes, read acknowledges and store requests have no effect. A stop during busy closes the transfer and drops its buffered bytes.
- R9: A store request with busy_o = 0, wp_i = 1 and status row bits 00 captures the chosen wiper and raises busy for BUSY_CYCLES cycles. The data register at row 0 of that column then holds the captured byte. Any other store request is ignored.
- R10: A committing stop and a store request in the same cycle: the stop wins and the store is dropped. A store that starts busy while a transfer has buffered bytes wins, and the later stop discards those bytes.
- R11: Wipers hold their value in every busy cycle that follows another busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_i | input | 1 | Write protect; 1 allows data-register commits |
| xfer_start_i | input | 1 | Pulse: addressed serial transfer begins |
| xfer_read_i | input | 1 | With xfer_start_i: 1 read transfer, 0 write transfer |
| wr_valid_i | input | 1 | Pulse: a byte of a write transfer was received |
| wr_byte_i | input | DW | Received byte |
| rd_next_i | input | 1 | Pulse: the presented read byte was acknowledged |
| xfer_stop_i | input | 1 | Pulse: serial transfer ended |
| store_req_i | input | 1 | Pulse: store a wiper into row 0 |
| store_dcp_i | input | CW | Channel whose wiper is stored |
| wiper_o | output | N_DCP*DW | All wiper registers, channel i at [i*DW +: DW] |
| rd_data_o | output | DW | Byte presented for serial read |
| busy_o | output | 1 | Recall or commit in progress |

## Verification
A wrong column pointer or row selection shows up in the cycle after the data byte or read acknowledge: the wrong wiper byte moves in wiper_o, or rd_data_o presents the wrong register. A commit that goes to the wrong place cannot be seen until busy_o falls. It is found by reading the row back, so every commit in the bench is followed by a full read of that row. A bench reference model compares wiper_o, busy_o and rd_data_o on every cycle, which catches a busy window that is too short, too long or missing on its exact edge.

// File: rtl/wbank_pkg.sv
package wbank_pkg;

    // Destination chosen by the last address byte
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_DCP  = 2'd1,
        TGT_STAT = 2'd2
    } tgt_e;

    // Address byte value that selects the status register
    localparam int STAT_ADDR = 7;

endpackage

// File: rtl/wbank_addr_decode.sv
module wbank_addr_decode
    import wbank_pkg::*;
#(
    parameter int N_DCP = 4,
    parameter int DW    = 8,
    localparam int CW   = (N_DCP > 1) ? $clog2(N_DCP) : 1
) (
    input  logic [DW-1:0] addr_byte_i,
    output tgt_e          tgt_o,
    output logic [CW-1:0] col_o
);

    always_comb begin
        tgt_o = TGT_NONE;
        col_o = '0;
        if (addr_byte_i < DW'(N_DCP)) begin
            tgt_o = TGT_DCP;
            col_o = addr_byte_i[CW-1:0];
        end else if (addr_byte_i == DW'(STAT_ADDR)) begin
            tgt_o = TGT_STAT;
        end
    end

endmodule

// File: rtl/wbank_read_mux.sv
module wbank_read_mux
    import wbank_pkg::*;
#(
    parameter int N_DCP = 4,
    parameter int N_ROW = 4,
    parameter int DW    = 8,
    localparam int CW   = (N_DCP > 1) ? $clog2(N_DCP) : 1,
    localparam int RW   = (N_ROW > 1) ? $clog2(N_ROW) : 1,
    localparam int SW   = RW + 1
) (
    input  tgt_e                                  tgt_i,
    input  logic [SW-1:0]                         stat_i,
    input  logic [CW-1:0]                         col_i,
    input  logic [N_DCP-1:0][DW-1:0]              wiper_i,
    input  logic [N_ROW-1:0][N_DCP-1:0][DW-1:0]   dr_i,
    output logic [DW-1:0]                         rd_data_o
);

    logic [RW-1:0] row;
    assign row = stat_i[SW-1:1];

    always_comb begin
        rd_data_o = '0;
        unique case (tgt_i)
            TGT_STAT: rd_data_o = DW'(stat_i);
            TGT_DCP:  rd_data_o = stat_i[0] ? dr_i[row][col_i] : wiper_i[col_i];
            default:  rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/wbank_busy_timer.sv
module wbank_busy_timer #(
    parameter int BUSY_CYCLES = 250000,
    localparam int TW = $clog2(BUSY_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else if (start_i) begin
            cnt_d = TW'(BUSY_CYCLES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy_o = (cnt_q != '0);
    assign done_o = (cnt_q == TW'(1));

endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
    import wbank_pkg::*;
#(
    parameter int N_DCP       = 4,
    parameter int N_ROW       = 4,
    parameter int DW          = 8,
    parameter int BUSY_CYCLES = 250000,
    parameter logic [N_ROW*N_DCP*DW-1:0] DR_INIT =
        128'h43424140_33323130_23222120_13121110,
    localparam int CW = (N_DCP > 1) ? $clog2(N_DCP) : 1,
    localparam int RW = (N_ROW > 1) ? $clog2(N_ROW) : 1,
    localparam int SW = RW + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wp_i,
    input  logic                  xfer_start_i,
    input  logic                  xfer_read_i,
    input  logic                  wr_valid_i,
    input  logic [DW-1:0]         wr_byte_i,
    input  logic                  rd_next_i,
    input  logic                  xfer_stop_i,
    input  logic                  store_req_i,
    input  logic [CW-1:0]         store_dcp_i,
    output logic [N_DCP*DW-1:0]   wiper_o,
    output logic [DW-1:0]         rd_data_o,
    output logic                  busy_o
);

    typedef struct packed {
        logic [N_ROW-1:0][N_DCP-1:0][DW-1:0] dr;
        logic [N_DCP-1:0][DW-1:0]            wiper;
        logic [N_DCP-1:0][DW-1:0]            pend;
        logic [N_DCP-1:0]                    pend_mask;
        logic [N_DCP-1:0][DW-1:0]            cm;
        logic [N_DCP-1:0]                    cm_mask;
        logic [RW-1:0]                       cm_row;
        logic [SW-1:0]                       stat;
        logic [CW-1:0]                       col;
        tgt_e                                tgt;
        logic                                active;
        logic                                is_read;
        logic                                want_addr;
        logic                                recall;
    } state_t;

    state_t st_d, st_q;

    // Column pointer advance with wrap inside the row
    function automatic logic [CW-1:0] col_step(input logic [CW-1:0] c);
        return (c == CW'(N_DCP - 1)) ? '0 : c + 1'b1;
    endfunction

    logic                     tmr_busy, tmr_done;
    logic                     commit_go;
    logic                     nv_sel;
    logic [RW-1:0]            sr_row;
    logic [RW-1:0]            new_row;
    logic [N_DCP-1:0]         mask_n;
    logic [N_DCP-1:0][DW-1:0] pend_n;
    tgt_e                     dec_tgt;
    logic [CW-1:0]            dec_col;

    assign nv_sel  = st_q.stat[0];
    assign sr_row  = st_q.stat[SW-1:1];
    assign new_row = wr_byte_i[SW-1:1];
    assign busy_o  = tmr_busy | st_q.recall;

    wbank_addr_decode #(
        .N_DCP (N_DCP),
        .DW    (DW)
    ) u_dec (
        .addr_byte_i (wr_byte_i),
        .tgt_o       (dec_tgt),
        .col_o       (dec_col)
    );

    wbank_busy_timer #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (commit_go),
        .busy_o  (tmr_busy),
        .done_o  (tmr_done)
    );

    wbank_read_mux #(
        .N_DCP (N_DCP),
        .N_ROW (N_ROW),
        .DW    (DW)
    ) u_rmux (
        .tgt_i     (st_q.tgt),
        .stat_i    (st_q.stat),
        .col_i     (st_q.col),
        .wiper_i   (st_q.wiper),
        .dr_i      (st_q.dr),
        .rd_data_o (rd_data_o)
    );

    always_comb begin
        st_d      = st_q;
        commit_go = 1'b0;
        mask_n    = st_q.pend_mask;
        pend_n    = st_q.pend;

        if (st_q.recall) begin
            // one-cycle recall of row 0 after reset
            st_d.recall = 1'b0;
            for (int j = 0; j < N_DCP; j++) begin
                st_d.wiper[j] = st_q.dr[0][j];
            end
        end else begin
            // storage write finishes at the last busy cycle
            if (tmr_done) begin
                for (int j = 0; j < N_DCP; j++) begin
                    if (st_q.cm_mask[j]) begin
                        st_d.dr[st_q.cm_row][j] = st_q.cm[j];
                    end
                end
                st_d.cm_mask = '0;
            end

            if (!busy_o) begin
                if (xfer_start_i) begin
                    st_d.active    = 1'b1;
                    st_d.is_read   = xfer_read_i;
                    st_d.want_addr = !xfer_read_i;
                    st_d.pend_mask = '0;
                end

                if (wr_valid_i && st_q.active && !st_q.is_read) begin
                    if (st_q.want_addr) begin
                        st_d.want_addr = 1'b0;
                        st_d.tgt       = dec_tgt;
                        st_d.col       = dec_col;
                    end else begin
                        unique case (st_q.tgt)
                            TGT_STAT: begin
                                st_d.stat = wr_byte_i[SW-1:0];
                                if (wr_byte_i[0]) begin
                                    for (int j = 0; j < N_DCP; j++) begin
                                        st_d.wiper[j] = st_q.dr[new_row][j];
                                    end
                                end
                            end
                            TGT_DCP: begin
                                if (!nv_sel) begin
                                    st_d.wiper[st_q.col] = wr_byte_i;
                                end else begin
                                    mask_n[st_q.col] = 1'b1;
                                    pend_n[st_q.col] = wr_byte_i;
                                    st_d.pend_mask   = mask_n;
                                    st_d.pend        = pend_n;
                                    for (int j = 0; j < N_DCP; j++) begin
                                        st_d.wiper[j] = mask_n[j] ? pend_n[j]
                                                                  : st_q.dr[sr_row][j];
                                    end
                                end
                                st_d.col = col_step(st_q.col);
                            end
                            default: ;
                        endcase
                    end
                end

                if (rd_next_i && st_q.active && st_q.is_read && st_q.tgt == TGT_DCP) begin
                    if (nv_sel) begin
                        st_d.wiper[st_q.col] = st_q.dr[sr_row][st_q.col];
                    end
                    st_d.col = col_step(st_q.col);
                end
            end

            // stop always closes the transfer; commit only when allowed
            if (xfer_stop_i && st_q.active) begin
                if (!busy_o && wp_i && st_q.pend_mask != '0) begin
                    commit_go    = 1'b1;
                    st_d.cm      = st_q.pend;
                    st_d.cm_mask = st_q.pend_mask;
                    st_d.cm_row  = sr_row;
                end
                st_d.active    = 1'b0;
                st_d.pend_mask = '0;
            end

            // store request from the up/down side loses a same-cycle tie
            if (store_req_i && !busy_o && wp_i && sr_row == '0 && !commit_go) begin
                commit_go                 = 1'b1;
                st_d.cm_mask              = '0;
                st_d.cm_mask[store_dcp_i] = 1'b1;
                st_d.cm[store_dcp_i]      = st_q.wiper[store_dcp_i];
                st_d.cm_row               = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.dr        <= DR_INIT;
            st_q.tgt       <= TGT_NONE;
            st_q.recall    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign wiper_o = st_q.wiper;

endmodule

// File: rtl/wiper_bank_chk.sv
module wiper_bank_chk #(
    parameter int BUSY_CYCLES = 16,
    parameter int WW          = 32,
    parameter int RW          = 2,
    localparam int TW         = $clog2(BUSY_CYCLES + 2)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wp_i,
    input logic          store_req_i,
    input logic          busy_o,
    input logic [WW-1:0] wiper_o,
    input logic [RW-1:0] sr_row
);

    logic [TW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy_o) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    // R6
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (run_q < TW'(BUSY_CYCLES)));

    // R6
    protect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_i && !busy_o) |=> !busy_o);

    // R9
    store_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req_i && wp_i && !busy_o && sr_row == '0) |=> busy_o);

    // R11
    wiper_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(wiper_o));

endmodule

bind wiper_bank wiper_bank_chk #(
    .BUSY_CYCLES (BUSY_CYCLES),
    .WW          (N_DCP * DW),
    .RW          (RW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wp_i        (wp_i),
    .store_req_i (store_req_i),
    .busy_o      (busy_o),
    .wiper_o     (wiper_o),
    .sr_row      (sr_row)
);

// File: tb/wiper_bank_test.sv
module wiper_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int BUSY       = 12;
    localparam logic [127:0] INIT = 128'h43424140_33323130_23222120_13121110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wp_i = 1'b1;
    logic        xfer_start_i = 1'b0;
    logic        xfer_read_i = 1'b0;
    logic        wr_valid_i = 1'b0;
    logic [7:0]  wr_byte_i = 8'h00;
    logic        rd_next_i = 1'b0;
    logic        xfer_stop_i = 1'b0;
    logic        store_req_i = 1'b0;
    logic [1:0]  store_dcp_i = 2'd0;
    logic [31:0] wiper_o;
    logic [7:0]  rd_data_o;
    logic        busy_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    wiper_bank #(
        .N_DCP (4), .N_ROW (4), .DW (8),
        .BUSY_CYCLES (BUSY), .DR_INIT (INIT)
    ) uut (
        .clk (clk), .rst_n (rst_n), .wp_i (wp_i),
        .xfer_start_i (xfer_start_i), .xfer_read_i (xfer_read_i),
        .wr_valid_i (wr_valid_i), .wr_byte_i (wr_byte_i),
        .rd_next_i (rd_next_i), .xfer_stop_i (xfer_stop_i),
        .store_req_i (store_req_i), .store_dcp_i (store_dcp_i),
        .wiper_o (wiper_o), .rd_data_o (rd_data_o), .busy_o (busy_o)
    );

    // ---------------- behavioural reference model ----------------
    int wm[4];
    int dm[4][4];
    int pv[4];
    bit pm[4];
    int cv[4];
    bit cmk[4];
    int crow, srm, colm, tgtm, bcnt;
    bit act, isrd, wantaddr, recm;

    function automatic bit mbusy();
        return (bcnt != 0) || recm;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < 4; r++)
                for (int j = 0; j < 4; j++)
                    dm[r][j] = int'(INIT[(r*4+j)*8 +: 8]);
            for (int j = 0; j < 4; j++) begin
                wm[j] = 0; pm[j] = 0; cmk[j] = 0; pv[j] = 0; cv[j] = 0;
            end
            srm = 0; colm = 0; tgtm = 0; bcnt = 0; crow = 0;
            act = 0; isrd = 0; wantaddr = 0; recm = 1;
        end else begin
            automatic bit bz = mbusy();
            automatic bit go = 0;
            automatic int row = srm >> 1;
            if (recm) begin
                for (int j = 0; j < 4; j++) wm[j] = dm[0][j];
                recm = 0;
            end else begin
                if (bcnt != 0) begin
                    bcnt--;
                    if (bcnt == 0)
                        for (int j = 0; j < 4; j++)
                            if (cmk[j]) dm[crow][j] = cv[j];
                end
                if (!bz) begin
                    if (xfer_start_i) begin
                        act = 1; isrd = xfer_read_i; wantaddr = !xfer_read_i;
                        for (int j = 0; j < 4; j++) pm[j] = 0;
                    end else if (wr_valid_i && act && !isrd) begin
                        automatic int b = int'(wr_byte_i);
                        if (wantaddr) begin
                            wantaddr = 0;
                            if (b < 4) begin tgtm = 1; colm = b; end
                            else if (b == 7) tgtm = 2;
                            else tgtm = 0;
                        end else if (tgtm == 2) begin
                            srm = b % 8;
                            if (b % 2 == 1)
                                for (int j = 0; j < 4; j++) wm[j] = dm[srm >> 1][j];
                        end else if (tgtm == 1) begin
                            if (srm % 2 == 0) wm[colm] = b;
                            else begin
                                pv[colm] = b; pm[colm] = 1;
                                for (int j = 0; j < 4; j++)
                                    wm[j] = pm[j] ? pv[j] : dm[row][j];
                            end
                            colm = (colm + 1) % 4;
                        end
                    end else if (rd_next_i && act && isrd && tgtm == 1) begin
                        if (srm % 2 == 1) wm[colm] = dm[row][colm];
                        colm = (colm + 1) % 4;
                    end
                end
                if (xfer_stop_i && act) begin
                    automatic bit any = pm[0] | pm[1] | pm[2] | pm[3];
                    if (!bz && wp_i && any) begin
                        go = 1; bcnt = BUSY; crow = row;
                        for (int j = 0; j < 4; j++) begin cv[j] = pv[j]; cmk[j] = pm[j]; end
                    end
                    act = 0;
                    for (int j = 0; j < 4; j++) pm[j] = 0;
                end
                if (store_req_i && !bz && wp_i && row == 0 && !go) begin
                    bcnt = BUSY; crow = 0;
                    for (int j = 0; j < 4; j++) cmk[j] = 0;
                    cmk[store_dcp_i] = 1;
                    cv[store_dcp_i] = wm[store_dcp_i];
                end
            end
        end
    end

    function automatic logic [31:0] exp_wiper();
        logic [31:0] w;
        for (int j = 0; j < 4; j++) w[j*8 +: 8] = 8'(wm[j]);
        return w;
    endfunction

    function automatic logic [7:0] exp_rd();
        if (tgtm == 2) return 8'(srm);
        if (tgtm == 1) return (srm % 2 == 1) ? 8'(dm[srm >> 1][colm]) : 8'(wm[colm]);
        return 8'h00;
    endfunction

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (wiper_o !== exp_wiper() || busy_o !== mbusy() || rd_data_o !== exp_rd()) begin
                fails++;
                $display("FAIL %s cycle compare: wiper=%h busy=%0d rd=%h expected wiper=%h busy=%0d rd=%h",
                         cur_req, wiper_o, busy_o, rd_data_o, exp_wiper(), mbusy(), exp_rd());
            end
        end
    end

    task automatic chk(string req, logic [31:0] act_v, logic [31:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
        end
    endtask

    // ---------------- stimulus helpers ----------------
    task automatic pulse(bit xs, bit xr, bit wv, logic [7:0] b, bit rn, bit sp, bit st, logic [1:0] sd);
        @(negedge clk);
        xfer_start_i = xs; xfer_read_i = xr; wr_valid_i = wv; wr_byte_i = b;
        rd_next_i = rn; xfer_stop_i = sp; store_req_i = st; store_dcp_i = sd;
        @(negedge clk);
        xfer_start_i = 0; xfer_read_i = 0; wr_valid_i = 0; wr_byte_i = 0;
        rd_next_i = 0; xfer_stop_i = 0; store_req_i = 0; store_dcp_i = 0;
    endtask

    task automatic t_start(bit rd); pulse(1, rd, 0, 8'h00, 0, 0, 0, 2'd0); endtask
    task automatic t_byte(logic [7:0] b); pulse(0, 0, 1, b, 0, 0, 0, 2'd0); endtask
    task automatic t_next(); pulse(0, 0, 0, 8'h00, 1, 0, 0, 2'd0); endtask
    task automatic t_stop(); pulse(0, 0, 0, 8'h00, 0, 1, 0, 2'd0); endtask
    task automatic t_store(logic [1:0] d); pulse(0, 0, 0, 8'h00, 0, 0, 1, d); endtask

    task automatic set_stat(logic [7:0] v);
        t_start(0); t_byte(8'h07); t_byte(v); t_stop();
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- test sequence ----------------
    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk("R1 reset busy", 32'(busy_o), 32'd1);
        chk("R1 reset wiper", wiper_o, 32'h0);
        rst_n = 1;
        chk("R1 recall cycle wiper", wiper_o, 32'h0);
        @(negedge clk);
        chk("R1 recalled row0", wiper_o, 32'h13121110);
        chk("R1 busy cleared", 32'(busy_o), 32'd0);

        cur_req = "R4";
        t_start(0); t_byte(8'h00);
        t_byte(8'h11); t_byte(8'h22); t_byte(8'h33); t_byte(8'h44); t_byte(8'h55);
        chk("R4 volatile page wrap", wiper_o, 32'h44332255);
        chk("R4 no busy", 32'(busy_o), 32'd0);
        t_stop();

        cur_req = "R7";
        t_start(1);
        chk("R7 read wiper col1", 32'(rd_data_o), 32'h22);
        t_next();
        chk("R7 read wiper col2", 32'(rd_data_o), 32'h33);
        t_stop();

        cur_req = "R3";
        t_start(0); t_byte(8'h07); t_byte(8'hFD);
        chk("R3 row2 loaded", wiper_o, 32'h33323130);
        t_stop();
        t_start(1);
        chk("R3 reserved bits read 0", 32'(rd_data_o), 32'h05);
        t_stop();

        cur_req = "R5";
        wp_i = 0;
        t_start(0); t_byte(8'h01); t_byte(8'h99);
        chk("R5 byte to wiper others from row", wiper_o, 32'h33329930);
        t_stop();
        chk("R6 protected stop no busy", 32'(busy_o), 32'd0);
        wp_i = 1;
        cur_req = "R7";
        t_start(0); t_byte(8'h01); t_stop();
        t_start(1);
        chk("R6 protected data kept", 32'(rd_data_o), 32'h31);
        t_next();
        chk("R7 read copies to wiper", wiper_o, 32'h33323130);
        chk("R7 next column", 32'(rd_data_o), 32'h32);
        t_stop();

        cur_req = "R5";
        t_start(0); t_byte(8'h03);
        t_byte(8'hA1); t_byte(8'hA2); t_byte(8'hA3); t_byte(8'hA4); t_byte(8'hA5);
        chk("R5 page wrap overwrite", wiper_o, 32'hA5A4A3A2);
        cur_req = "R6";
        t_stop();
        n = 0;
        while (busy_o) begin n++; @(negedge clk); end
        chk("R6 busy length", 32'(n), 32'(BUSY));
        t_start(0); t_byte(8'h00); t_stop();
        t_start(1);
        chk("R6 committed col0", 32'(rd_data_o), 32'hA2);
        t_next(); chk("R6 committed col1", 32'(rd_data_o), 32'hA3);
        t_next(); chk("R6 committed col2", 32'(rd_data_o), 32'hA4);
        t_next(); chk("R6 committed col3", 32'(rd_data_o), 32'hA5);
        t_stop();

        cur_req = "R2";
        t_start(0); t_byte(8'h05); t_byte(8'h77); t_stop();
        chk("R2 unused address no write", wiper_o, 32'hA5A4A3A2);
        t_start(1);
        chk("R2 unused reads zero", 32'(rd_data_o), 32'h00);
        t_stop();
        t_start(0); t_byte(8'h13); t_byte(8'h78); t_stop();
        chk("R2 high address no write", wiper_o, 32'hA5A4A3A2);

        cur_req = "R9";
        set_stat(8'h00);
        t_store(2'd2);
        chk("R9 store busy", 32'(busy_o), 32'd1);
        cur_req = "R8";
        t_start(0); t_byte(8'h02); t_byte(8'h5E); t_store(2'd1);
        chk("R8 ignored while busy", wiper_o, 32'hA5A4A3A2);
        wait_idle();
        t_stop();
        cur_req = "R9";
        set_stat(8'h01);
        chk("R9 stored into row0", wiper_o, 32'h13A41110);
        set_stat(8'h02);
        t_store(2'd0);
        chk("R9 store needs row0", 32'(busy_o), 32'd0);
        set_stat(8'h00);
        wp_i = 0;
        t_store(2'd0);
        chk("R9 store needs wp", 32'(busy_o), 32'd0);
        wp_i = 1;

        cur_req = "R10";
        set_stat(8'h01);
        t_start(0); t_byte(8'h00); t_byte(8'h66);
        chk("R5 buffered byte with row", wiper_o, 32'h13A41166);
        pulse(0, 0, 0, 8'h00, 0, 1, 1, 2'd1);
        chk("R10 serial commit busy", 32'(busy_o), 32'd1);
        wait_idle();
        t_start(0); t_byte(8'h01); t_byte(8'h77);
        t_store(2'd3);
        chk("R10 store wins busy", 32'(busy_o), 32'd1);
        t_stop();
        wait_idle();
        t_start(0); t_byte(8'h00); t_stop();
        t_start(1);
        chk("R10 serial won tie", 32'(rd_data_o), 32'h66);
        t_next(); chk("R10 late stop discarded", 32'(rd_data_o), 32'h11);
        t_next(); chk("R10 col2 kept", 32'(rd_data_o), 32'hA4);
        t_next(); chk("R10 store committed", 32'(rd_data_o), 32'h13);
        t_next();
        chk("R11 wipers after reads", wiper_o, 32'h13A41166);
        t_stop();
        repeat (3) @(negedge clk);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule